// File: doc/BRIEF.md
# Trigger Condition Sequencer

This block decides when a scope trigger fires. Analysis blocks that always run next to it (edge detectors, serial shift registers and pattern matchers) give it one-cycle event strobes and a captured byte. The sequencer does not look at raw samples. It runs a short program of steps. Each step waits for one condition, and when that condition is resolved the step picks what happens next: go to another step, go to a miss step, or fire the trigger.

Each step can also watch one abort event. When that event arrives, the machine jumps to a chosen step, usually the start, whatever the main condition is doing. A step's condition can be one of four kinds:

- a plain event;
- an event with a masked byte compare;
- a fixed delay counted in clock cycles;
- "never", which only the abort can leave.

Software loads the steps through a small write port. It then arms the machine. After a trigger fires, the machine stays idle until it is armed again.

Top module: `trig_seq`

## Requirements
- R1: After reset the machine is idle. In that state trig_o is 0 and pc_o is 0. Until arm_i is pulsed, no event changes pc_o or raises trig_o.
- R2: In any state, a cycle with arm_i high sets pc_o to 0 at the next edge and starts the program. Arm takes priority over every condition and abort in the same cycle.
- R3: Kind 1 (event) takes next_match when evt_i[evt_sel] is high. pc_o changes at the clock edge that ends that cycle. In a cycle with no such event the step holds.
- R4: Kind 2 (compare) acts on evt_i[evt_sel]. It compares data_i with cmp_val, and only the bits set in cmp_mask count. If they are equal it takes next_match, otherwise it takes next_miss.
- R5: Kind 3 (delay) loads a counter with the step's delay value D on every entry to the step. The step is satisfied once the counter has counted down to zero, so the machine stays in the step for D+1 cycles before it acts on the match.
- R6: When abort_en is set and evt_i[abort_evt] is high, the next pc_o is abort_tgt. This takes priority over the step's own condition in the same cycle.
- R7: A satisfied condition on a step with the fire bit set does three things. It drives trig_o high for exactly one cycle, starting at the same edge where a goto would have changed pc_o. It leaves pc_o unchanged. It disarms the machine, so later events have no effect until the next arm.
- R8: The write port stores prog_wdata into step prog_addr at a clock edge where prog_we is high. prog_sel chooses the word: 0 is control, 1 is delay, 2 is mask (byte in bits 7:0). The control word fields are:
  - kind: bits 1:0
  - fire: bit 2
  - abort_en: bit 3
  - evt_sel: bits 7:4
  - abort_evt: bits 11:8
  - next_match: bits 15:12
  - next_miss: bits 19:16
  - abort_tgt: bits 23:20
  - cmp_val: bits 31:24
- R9: Kind 0 (hold) is never satisfied. The step holds until an abort or an arm. After reset every step's words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | 4 | Step index to write |
| prog_sel | input | 2 | Word select: 0 control, 1 delay, 2 mask |
| prog_wdata | input | 32 | Program write data |
| arm_i | input | 1 | Restart the program at step 0 |
| evt_i | input | 8 | Event strobes from the analysis blocks |
| data_i | input | 8 | Byte that goes with the compare event |
| trig_o | output | 1 | One-cycle trigger pulse |
| pc_o | output | 4 | Current step index |

## Verification
Several properties are checked on every cycle:
- the machine is frozen while it is idle;
- arm restarts it at step 0;
- an abort beats the main condition;
- a hold step, or a delay step whose counter has not run out, does not move;
- trig_o is a single-cycle pulse and leaves the machine disarmed.

Other behaviour depends on program contents and event order, so only the directed scenarios can show it. These scenarios cover the byte match with masking, mismatch branches from each compare step, the exact D+1 cycle length of a delay step, and the full two-byte serial match that ends in a trigger.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int SLOT_W = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_DELAY = 2'd1;
    localparam logic [1:0] SEL_MASK  = 2'd2;

    typedef enum logic [1:0] {
        K_HOLD  = 2'd0,
        K_EVENT = 2'd1,
        K_CMP   = 2'd2,
        K_DELAY = 2'd3
    } cond_kind_e;

    // Packed from MSB down; kind ends up in bits 1:0.
    typedef struct packed {
        logic [BYTE_W-1:0] cmp_val;
        logic [SLOT_W-1:0] abort_tgt;
        logic [SLOT_W-1:0] nxt_miss;
        logic [SLOT_W-1:0] nxt_match;
        logic [SLOT_W-1:0] abort_evt;
        logic [SLOT_W-1:0] evt_sel;
        logic              abort_en;
        logic              fire;
        cond_kind_e        kind;
    } step_ctrl_t;

endpackage

// File: rtl/trig_seq_prog.sv
module trig_seq_prog
    import trig_seq_pkg::*;
#(
    parameter int NUM_STATES = 16,
    parameter int CNT_W      = 32,
    localparam int STATE_W   = $clog2(NUM_STATES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [STATE_W-1:0]  waddr,
    input  logic [1:0]          wsel,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [STATE_W-1:0]  cur_addr,
    output step_ctrl_t          cur_ctrl,
    output logic [BYTE_W-1:0]   cur_mask,
    input  logic [STATE_W-1:0]  nxt_addr,
    output logic [CNT_W-1:0]    nxt_delay
);

    step_ctrl_t        ctrl_q  [NUM_STATES];
    logic [BYTE_W-1:0] mask_q  [NUM_STATES];
    logic [CNT_W-1:0]  delay_q [NUM_STATES];

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_row
        logic hit;
        assign hit = we && (waddr == STATE_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[i]  <= '0;
                mask_q[i]  <= '0;
                delay_q[i] <= '0;
            end else if (hit) begin
                if (wsel == SEL_CTRL)  ctrl_q[i]  <= step_ctrl_t'(wdata);
                if (wsel == SEL_DELAY) delay_q[i] <= wdata[CNT_W-1:0];
                if (wsel == SEL_MASK)  mask_q[i]  <= wdata[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        cur_ctrl  = '0;
        cur_mask  = '0;
        nxt_delay = '0;
        if (int'(cur_addr) < NUM_STATES) begin
            cur_ctrl = ctrl_q[cur_addr];
            cur_mask = mask_q[cur_addr];
        end
        if (int'(nxt_addr) < NUM_STATES) begin
            nxt_delay = delay_q[nxt_addr];
        end
    end

endmodule

// File: rtl/trig_seq_eval.sv
module trig_seq_eval
    import trig_seq_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  cond_kind_e          kind,
    input  logic [SLOT_W-1:0]   evt_sel,
    input  logic                abort_en,
    input  logic [SLOT_W-1:0]   abort_evt,
    input  logic [BYTE_W-1:0]   cmp_val,
    input  logic [BYTE_W-1:0]   cmp_mask,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic [BYTE_W-1:0]   data_i,
    input  logic                cnt_zero,
    output logic                cond_hit,
    output logic                cond_match,
    output logic                abort_hit
);

    localparam int SLOT_N = 1 << SLOT_W;

    logic [SLOT_N-1:0] evt_pad;
    logic              evt_pick;
    logic              byte_eq;

    always_comb begin
        evt_pad  = SLOT_N'(evt_i);
        evt_pick = evt_pad[evt_sel];
        byte_eq  = ((data_i ^ cmp_val) & cmp_mask) == '0;
        abort_hit = abort_en && evt_pad[abort_evt];

        cond_hit   = 1'b0;
        cond_match = 1'b0;
        unique case (kind)
            K_HOLD: begin
                cond_hit   = 1'b0;
                cond_match = 1'b0;
            end
            K_EVENT: begin
                cond_hit   = evt_pick;
                cond_match = 1'b1;
            end
            K_CMP: begin
                cond_hit   = evt_pick;
                cond_match = byte_eq;
            end
            K_DELAY: begin
                cond_hit   = cnt_zero;
                cond_match = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trig_seq_timer.sv
module trig_seq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int NUM_EVT    = 8,
    parameter int NUM_STATES = 16,
    parameter int CNT_W      = 32,
    localparam int STATE_W   = $clog2(NUM_STATES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_we,
    input  logic [STATE_W-1:0]  prog_addr,
    input  logic [1:0]          prog_sel,
    input  logic [WORD_W-1:0]   prog_wdata,
    input  logic                arm_i,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                trig_o,
    output logic [STATE_W-1:0]  pc_o
);

    typedef struct packed {
        logic               armed;
        logic [STATE_W-1:0] pc;
        logic               trig;
    } seq_t;

    seq_t s_d, s_q;

    step_ctrl_t        cur_ctrl;
    logic [BYTE_W-1:0] cur_mask;
    logic [CNT_W-1:0]  nxt_delay;
    logic              cond_hit, cond_match, abort_hit;
    logic              cnt_zero;
    logic              load;
    logic              run;
    logic              armed_w;
    logic [STATE_W-1:0] abort_tgt_w;
    cond_kind_e        kind_w;

    trig_seq_prog #(
        .NUM_STATES (NUM_STATES),
        .CNT_W      (CNT_W)
    ) i_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (prog_we),
        .waddr     (prog_addr),
        .wsel      (prog_sel),
        .wdata     (prog_wdata),
        .cur_addr  (s_q.pc),
        .cur_ctrl  (cur_ctrl),
        .cur_mask  (cur_mask),
        .nxt_addr  (s_d.pc),
        .nxt_delay (nxt_delay)
    );

    trig_seq_eval #(
        .NUM_EVT (NUM_EVT)
    ) i_eval (
        .kind       (cur_ctrl.kind),
        .evt_sel    (cur_ctrl.evt_sel),
        .abort_en   (cur_ctrl.abort_en),
        .abort_evt  (cur_ctrl.abort_evt),
        .cmp_val    (cur_ctrl.cmp_val),
        .cmp_mask   (cur_mask),
        .evt_i      (evt_i),
        .data_i     (data_i),
        .cnt_zero   (cnt_zero),
        .cond_hit   (cond_hit),
        .cond_match (cond_match),
        .abort_hit  (abort_hit)
    );

    assign run = s_q.armed && (cur_ctrl.kind == K_DELAY);

    trig_seq_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (nxt_delay),
        .run      (run),
        .zero_o   (cnt_zero)
    );

    // Next-state: arm, then abort, then the step's own condition.
    always_comb begin
        s_d      = s_q;
        s_d.trig = 1'b0;
        load     = 1'b0;
        if (arm_i) begin
            s_d.armed = 1'b1;
            s_d.pc    = '0;
            load      = 1'b1;
        end else if (s_q.armed) begin
            if (abort_hit) begin
                s_d.pc = cur_ctrl.abort_tgt[STATE_W-1:0];
                load   = 1'b1;
            end else if (cond_hit) begin
                if (!cond_match) begin
                    s_d.pc = cur_ctrl.nxt_miss[STATE_W-1:0];
                    load   = 1'b1;
                end else if (cur_ctrl.fire) begin
                    s_d.trig  = 1'b1;
                    s_d.armed = 1'b0;
                end else begin
                    s_d.pc = cur_ctrl.nxt_match[STATE_W-1:0];
                    load   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trig_o      = s_q.trig;
    assign pc_o        = s_q.pc;
    assign armed_w     = s_q.armed;
    assign abort_tgt_w = cur_ctrl.abort_tgt[STATE_W-1:0];
    assign kind_w      = cur_ctrl.kind;

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
    import trig_seq_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arm_i,
    input logic               trig_o,
    input logic [STATE_W-1:0] pc_o,
    input logic               armed,
    input logic               abort_hit,
    input logic [STATE_W-1:0] abort_tgt,
    input cond_kind_e         kind,
    input logic               cnt_zero
);

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_i) |=> ($stable(pc_o) && !trig_o)); // R1

    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (pc_o == '0 && armed && !trig_o)); // R2

    AST_DELAY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_i && !abort_hit && kind == K_DELAY && !cnt_zero)
        |=> ($stable(pc_o) && !trig_o)); // R5

    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_i && abort_hit) |=> (pc_o == $past(abort_tgt) && !trig_o)); // R6

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R7

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !armed); // R7

    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_i && !abort_hit && kind == K_HOLD)
        |=> ($stable(pc_o) && !trig_o)); // R9

endmodule

bind trig_seq trig_seq_chk #(.STATE_W(STATE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .trig_o    (trig_o),
    .pc_o      (pc_o),
    .armed     (armed_w),
    .abort_hit (abort_hit),
    .abort_tgt (abort_tgt_w),
    .kind      (kind_w),
    .cnt_zero  (cnt_zero)
);

// File: tb/test_trig_seq.sv
module test_trig_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EVT    = 8;

    localparam logic [1:0] KH = 2'd0, KE = 2'd1, KC = 2'd2, KD = 2'd3;
    localparam int EV_AFALL = 0, EV_ARISE = 1, EV_BYTE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [3:0]  prog_addr = '0;
    logic [1:0]  prog_sel = '0;
    logic [31:0] prog_wdata = '0;
    logic        arm_i = 1'b0;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic [7:0]  data_i = '0;
    logic        trig_o;
    logic [3:0]  pc_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    trig_seq i_trig_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_sel   (prog_sel),
        .prog_wdata (prog_wdata),
        .arm_i      (arm_i),
        .evt_i      (evt_i),
        .data_i     (data_i),
        .trig_o     (trig_o),
        .pc_o       (pc_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctrl_word(
        input logic [1:0] kind, input logic fire, input logic aen,
        input int evt, input int aevt, input int nm, input int nmiss,
        input int atgt, input logic [7:0] val);
        ctrl_word = {val, 4'(atgt), 4'(nmiss), 4'(nm), 4'(aevt), 4'(evt),
                     aen, fire, kind};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_word(input int addr, input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 4'(addr); prog_sel = sel; prog_wdata = val;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] ev, input logic [7:0] d);
        @(negedge clk);
        evt_i = ev; data_i = d;
        @(negedge clk);
        evt_i = '0; data_i = '0;
    endtask

    task automatic arm();
        @(negedge clk);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    function automatic logic [NUM_EVT-1:0] ev(input int b);
        ev = NUM_EVT'(1) << b;
    endfunction

    task automatic load_spi();
        write_word(0, 2'd0, ctrl_word(KE, 0, 0, EV_AFALL, 0, 1, 0, 0, 8'h00));
        write_word(1, 2'd0, ctrl_word(KC, 0, 1, EV_BYTE, EV_ARISE, 2, 0, 0, 8'h41));
        write_word(1, 2'd2, 32'hFF);
        write_word(2, 2'd0, ctrl_word(KC, 1, 1, EV_BYTE, EV_ARISE, 0, 0, 0, 8'h42));
        write_word(2, 2'd2, 32'hFF);
    endtask

    task automatic t_reset_idle();
        check("R1", "trig after reset", int'(trig_o), 0);
        check("R1", "pc after reset", int'(pc_o), 0);
        pulse(ev(EV_BYTE), 8'h00);
        check("R9", "zero program holds", int'(pc_o), 0);
        load_spi();
        pulse(ev(EV_AFALL), 8'h00);
        check("R1", "unarmed event ignored pc", int'(pc_o), 0);
        check("R1", "unarmed event ignored trig", int'(trig_o), 0);
    endtask

    task automatic t_spi_match();
        arm();
        check("R2", "pc after arm", int'(pc_o), 0);
        pulse('0, 8'h00);
        check("R3", "no event holds", int'(pc_o), 0);
        pulse(ev(EV_AFALL), 8'h00);
        check("R3", "event advances", int'(pc_o), 1);
        pulse(ev(EV_BYTE), 8'h41);
        check("R4", "first byte match R8", int'(pc_o), 2);
        pulse(ev(EV_BYTE), 8'h42);
        check("R7", "trigger high", int'(trig_o), 1);
        check("R7", "pc held on fire", int'(pc_o), 2);
        @(negedge clk);
        check("R7", "trigger one cycle", int'(trig_o), 0);
        pulse(ev(EV_ARISE), 8'h00);
        check("R7", "disarmed abort ignored", int'(pc_o), 2);
        pulse(ev(EV_BYTE), 8'h42);
        check("R7", "disarmed no refire", int'(trig_o), 0);
        arm();
        check("R2", "rearm restarts", int'(pc_o), 0);
    endtask

    task automatic t_mismatch();
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        pulse(ev(EV_BYTE), 8'h40);
        check("R4", "step1 miss to 0", int'(pc_o), 0);
        pulse(ev(EV_AFALL), 8'h00);
        pulse(ev(EV_BYTE), 8'h41);
        pulse(ev(EV_BYTE), 8'h43);
        check("R4", "step2 miss to 0", int'(pc_o), 0);
        check("R4", "miss no trigger", int'(trig_o), 0);
    endtask

    task automatic t_abort();
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        pulse(ev(EV_ARISE) | ev(EV_BYTE), 8'h41);
        check("R6", "abort beats match", int'(pc_o), 0);
    endtask

    task automatic t_mask();
        write_word(1, 2'd0, ctrl_word(KC, 0, 1, EV_BYTE, EV_ARISE, 2, 0, 0, 8'h40));
        write_word(1, 2'd2, 32'hF0);
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        pulse(ev(EV_BYTE), 8'h4F);
        check("R4", "masked bits ignored", int'(pc_o), 2);
        write_word(1, 2'd0, ctrl_word(KC, 0, 1, EV_BYTE, EV_ARISE, 2, 0, 0, 8'h41));
        write_word(1, 2'd2, 32'hFF);
    endtask

    task automatic t_delay();
        write_word(5, 2'd0, ctrl_word(KD, 1, 0, 0, 0, 0, 0, 0, 8'h00));
        write_word(5, 2'd1, 32'd4);
        write_word(0, 2'd0, ctrl_word(KE, 0, 0, EV_AFALL, 0, 5, 0, 0, 8'h00));
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        check("R5", "entered delay step", int'(pc_o), 5);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R5", $sformatf("no trigger at wait %0d", k), int'(trig_o), 0);
        end
        @(negedge clk);
        check("R5", "trigger after D+1 cycles", int'(trig_o), 1);
        write_word(0, 2'd0, ctrl_word(KE, 0, 0, EV_AFALL, 0, 1, 0, 0, 8'h00));
    endtask

    task automatic t_hold();
        write_word(6, 2'd0, ctrl_word(KH, 0, 1, 0, EV_ARISE, 0, 0, 0, 8'h00));
        write_word(0, 2'd0, ctrl_word(KE, 0, 0, EV_AFALL, 0, 6, 0, 0, 8'h00));
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        check("R9", "entered hold step", int'(pc_o), 6);
        pulse(ev(EV_AFALL) | ev(EV_BYTE), 8'h00);
        check("R9", "hold ignores events", int'(pc_o), 6);
        pulse(ev(EV_ARISE), 8'h00);
        check("R9", "abort leaves hold", int'(pc_o), 0);
        write_word(0, 2'd0, ctrl_word(KE, 0, 0, EV_AFALL, 0, 1, 0, 0, 8'h00));
    endtask

    task automatic t_arm_priority();
        arm();
        pulse(ev(EV_AFALL), 8'h00);
        @(negedge clk);
        arm_i = 1'b1; evt_i = ev(EV_BYTE); data_i = 8'h41;
        @(negedge clk);
        arm_i = 1'b0; evt_i = '0; data_i = '0;
        check("R2", "arm beats match", int'(pc_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_spi_match();
        t_mismatch();
        t_abort();
        t_mask();
        t_delay();
        t_hold();
        t_arm_priority();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish");
        finish_run();
    end

endmodule